// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the state update a small processor core makes when it takes an exception. Each cycle it looks at a vector of pending exception requests. It picks one by fixed priority. From the current program counter, the current status word and a configuration input, it computes everything the core must write back. That covers the new status word with its mode and interrupt masks, the saved-status bank that receives the old status, the link value and the new program counter. The configuration input selects a full 32-bit address mode or a legacy 26-bit mode. In the legacy mode the flags, masks and mode share one word with the program counter.

The register file is not part of the block. A single-cycle strobe presents the results, and surrounding logic commits them to the banked registers and the fetch unit. The reset request is treated as an exception in its own right: it forces a fully defined starting status and program counter.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, entry_o is 0 and ack_o is all zeros.
- R2: A request vector sampled at a rising edge produces entry_o high for exactly the following cycle, with exactly one ack_o bit set. An all-zero request vector produces entry_o low and ack_o zero. Request bit index = exception code: 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 address exception, 6 IRQ, 7 FIQ.
- R3: When several requests are pending together, exactly one is taken, in the order reset, data abort, address exception, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt (highest first).
- R4: The vector address of exception code k is 4*k.
- R5: With cfg32_i=1, status bits [4:0] of the new status are: 0x13 for reset and software interrupt, 0x1B for undefined instruction, 0x17 for both aborts, 0x12 for IRQ, 0x11 for FIQ, and 0x03 for the address exception.
- R6: With cfg32_i=0, the mode field is 0x02 for IRQ, 0x01 for FIQ and 0x03 for every other exception.
- R7: spsr_bank_o selects the bank (0 supervisor, 1 abort, 2 undefined, 3 IRQ, 4 FIQ) by target mode. With cfg32_i=0, undefined instruction and both aborts use bank 0. spsr_data_o equals the status word sampled with the request.
- R8: The I mask (status bit 7) is set on every entry. The F mask (bit 6) is set for reset and FIQ and is otherwise copied unchanged. For non-reset entries, bits 31:8 and 5 are copied unchanged.
- R9: The link base is as follows. With cfg32_i=1 and status bit 4 set, it is pc_i. With cfg32_i=1 and bit 4 clear, it is pc_i & 0x03FFFFFC. lr_data_o is the base minus 4 (mod 2^32) for every exception except reset, which writes the base unchanged.
- R10: With cfg32_i=0, the link base is the packed word {status[31:28], status[7], status[6], pc_i[25:2], status[1:0]}. When the new mode has bit 4 clear, new_pc_o is that same packing of the new status with the vector address; otherwise new_pc_o is the vector address.
- R11: A reset entry yields new status 0x000000D3 and new_pc_o 0 with cfg32_i=1. With cfg32_i=0 it yields new status 0x000000C3 and new_pc_o 0x0C000003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg32_i | input | 1 | 1 selects 32-bit configuration, 0 legacy 26-bit |
| req_i | input | 8 | Pending exception requests, bit index = exception code |
| pc_i | input | 32 | Current return address / program counter word |
| status_i | input | 32 | Current status word |
| entry_o | output | 1 | One-cycle strobe: all result outputs valid |
| ack_o | output | 8 | One-hot code of the exception taken |
| new_pc_o | output | 32 | Program counter to fetch from |
| new_status_o | output | 32 | Status word after entry |
| spsr_bank_o | output | 3 | Saved-status bank to write |
| spsr_data_o | output | 32 | Old status to save |
| lr_data_o | output | 32 | Value for the target mode link register |

## Verification
Every result is registered once. An input set sampled at a rising edge is therefore due on the outputs throughout the next cycle and gone one cycle after the request drops. The bench drives inputs on the falling edge, waits one rising edge, then samples every output on the following falling edge. It then clears the request and confirms that the strobe falls after one more edge. Expected values come from a reference written from the mode, bank, mask and packing rules. This reference is applied to every exception code in both configurations, to status words with masks already set, to legacy modes under the 32-bit configuration and to overlapping request sets.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_EXC = 8;
  localparam int XW      = 32;
  localparam int I_BIT   = 7;
  localparam int F_BIT   = 6;

  typedef enum logic [2:0] {
    EXC_RST  = 3'd0, EXC_UND  = 3'd1, EXC_SWI = 3'd2, EXC_PABT = 3'd3,
    EXC_DABT = 3'd4, EXC_ADDR = 3'd5, EXC_IRQ = 3'd6, EXC_FIQ  = 3'd7
  } exc_e;

  typedef enum logic [2:0] {
    BANK_SVC = 3'd0, BANK_ABT = 3'd1, BANK_UND = 3'd2,
    BANK_IRQ = 3'd3, BANK_FIQ = 3'd4
  } bank_e;

  localparam logic [4:0] M_FIQ32 = 5'h11;
  localparam logic [4:0] M_IRQ32 = 5'h12;
  localparam logic [4:0] M_SVC32 = 5'h13;
  localparam logic [4:0] M_ABT32 = 5'h17;
  localparam logic [4:0] M_UND32 = 5'h1B;
  localparam logic [4:0] M_FIQ26 = 5'h01;
  localparam logic [4:0] M_IRQ26 = 5'h02;
  localparam logic [4:0] M_SVC26 = 5'h03;

  // legacy word: flags, I, F, word address, mode
  function automatic logic [XW-1:0] pack26(logic [XW-1:0] st, logic [XW-1:0] addr);
    return {st[31:28], st[I_BIT], st[F_BIT], addr[25:2], st[1:0]};
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_EXC
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output exc_e         id_o,
  output logic [N-1:0] grant_o
);
  // highest priority first
  localparam exc_e PRIO [NUM_EXC] = '{EXC_RST, EXC_DABT, EXC_ADDR, EXC_FIQ,
                                      EXC_IRQ, EXC_PABT, EXC_UND, EXC_SWI};

  always_comb begin
    id_o  = EXC_RST;
    any_o = |req_i;
    for (int k = NUM_EXC - 1; k >= 0; k--) begin
      if (req_i[PRIO[k]]) id_o = PRIO[k];
    end
    grant_o = any_o ? (N'(1) << id_o) : '0;
  end
endmodule

// File: rtl/exc_map.sv
module exc_map
  import exc_pkg::*;
(
  input  exc_e       id_i,
  input  logic       cfg32_i,
  output logic [4:0] mode_o,
  output bank_e      bank_o,
  output logic       set_f_o
);
  always_comb begin
    set_f_o = (id_i == EXC_RST) || (id_i == EXC_FIQ);
    mode_o  = M_SVC26;
    bank_o  = BANK_SVC;
    unique case (id_i)
      EXC_RST, EXC_SWI: mode_o = cfg32_i ? M_SVC32 : M_SVC26;
      EXC_UND: begin
        mode_o = cfg32_i ? M_UND32 : M_SVC26;
        bank_o = cfg32_i ? BANK_UND : BANK_SVC;
      end
      EXC_PABT, EXC_DABT: begin
        mode_o = cfg32_i ? M_ABT32 : M_SVC26;
        bank_o = cfg32_i ? BANK_ABT : BANK_SVC;
      end
      EXC_ADDR: mode_o = M_SVC26;
      EXC_IRQ: begin
        mode_o = cfg32_i ? M_IRQ32 : M_IRQ26;
        bank_o = BANK_IRQ;
      end
      EXC_FIQ: begin
        mode_o = cfg32_i ? M_FIQ32 : M_FIQ26;
        bank_o = BANK_FIQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_word.sv
module exc_word
  import exc_pkg::*;
(
  input  exc_e          id_i,
  input  logic          cfg32_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] status_i,
  input  logic [4:0]    mode_i,
  input  logic          set_f_i,
  output logic [XW-1:0] status_o,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] link_o
);
  localparam logic [XW-1:0] PC26_MASK = 32'h03FF_FFFC;

  logic [XW-1:0] vec_addr;
  logic [XW-1:0] link_base;
  logic          is_rst;

  assign is_rst   = (id_i == EXC_RST);
  assign vec_addr = XW'({id_i, 2'b00});

  always_comb begin
    if (cfg32_i) link_base = status_i[4] ? pc_i : (pc_i & PC26_MASK);
    else         link_base = pack26(status_i, pc_i);
    link_o = is_rst ? link_base : link_base - XW'(4);

    if (is_rst) begin
      status_o = '0;
      status_o[I_BIT] = 1'b1;
      status_o[F_BIT] = 1'b1;
      status_o[4:0]   = mode_i;
    end else begin
      status_o        = status_i;
      status_o[I_BIT] = 1'b1;
      status_o[F_BIT] = status_i[F_BIT] | set_f_i;
      status_o[4:0]   = mode_i;
    end

    pc_o = mode_i[4] ? vec_addr : pack26(status_o, vec_addr);
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg32_i,
  input  logic [NUM_EXC-1:0]  req_i,
  input  logic [XW-1:0]       pc_i,
  input  logic [XW-1:0]       status_i,
  output logic                entry_o,
  output logic [NUM_EXC-1:0]  ack_o,
  output logic [XW-1:0]       new_pc_o,
  output logic [XW-1:0]       new_status_o,
  output logic [2:0]          spsr_bank_o,
  output logic [XW-1:0]       spsr_data_o,
  output logic [XW-1:0]       lr_data_o
);
  logic               any;
  exc_e               id;
  logic [NUM_EXC-1:0] grant;
  logic [4:0]         mode;
  bank_e              bank;
  logic               set_f;
  logic [XW-1:0]      nxt_status, nxt_pc, nxt_link;

  exc_arbiter #(.N(NUM_EXC)) u_arb (
    .req_i(req_i), .any_o(any), .id_o(id), .grant_o(grant)
  );

  exc_map u_map (
    .id_i(id), .cfg32_i(cfg32_i), .mode_o(mode), .bank_o(bank), .set_f_o(set_f)
  );

  exc_word u_word (
    .id_i(id), .cfg32_i(cfg32_i), .pc_i(pc_i), .status_i(status_i),
    .mode_i(mode), .set_f_i(set_f),
    .status_o(nxt_status), .pc_o(nxt_pc), .link_o(nxt_link)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o      <= 1'b0;
      ack_o        <= '0;
      new_pc_o     <= '0;
      new_status_o <= '0;
      spsr_bank_o  <= '0;
      spsr_data_o  <= '0;
      lr_data_o    <= '0;
    end else begin
      entry_o <= any;
      ack_o   <= grant;
      if (any) begin
        new_pc_o     <= nxt_pc;
        new_status_o <= nxt_status;
        spsr_bank_o  <= bank;
        spsr_data_o  <= status_i;
        lr_data_o    <= nxt_link;
      end
    end
  end
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cfg32_i,
  input logic [7:0]  req_i,
  input logic [31:0] pc_i,
  input logic [31:0] status_i,
  input logic        entry_o,
  input logic [7:0]  ack_o,
  input logic [31:0] new_pc_o,
  input logic [31:0] new_status_o,
  input logic [2:0]  spsr_bank_o,
  input logic [31:0] spsr_data_o,
  input logic [31:0] lr_data_o
);
  a_r2_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> $countones(ack_o) == 1);
  a_r2_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry_o |-> ack_o == 8'h00);
  a_r2_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> entry_o);
  a_r2_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> !entry_o);
  a_r3_reset_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i[0] |=> ack_o[0]);
  a_r8_i_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> new_status_o[7]);
  a_r8_f_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && (ack_o[0] || ack_o[7])) |-> new_status_o[6]);
  a_r7_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> spsr_data_o == $past(status_i));
  a_r9_link32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|req_i) && !req_i[0] && cfg32_i && status_i[4]) |=> lr_data_o == $past(pc_i) - 32'd4);
endmodule

bind exc_entry_ctrl exc_entry_checker u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg32 = 1'b1;
  logic [7:0]  req = '0;
  logic [31:0] pc = '0;
  logic [31:0] st = '0;
  logic        entry;
  logic [7:0]  ack;
  logic [31:0] npc, nst, sdata, lr;
  logic [2:0]  bank;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg32_i(cfg32), .req_i(req), .pc_i(pc),
    .status_i(st), .entry_o(entry), .ack_o(ack), .new_pc_o(npc),
    .new_status_o(nst), .spsr_bank_o(bank), .spsr_data_o(sdata), .lr_data_o(lr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pk(logic [31:0] s, logic [31:0] a);
    return {s[31:28], s[7], s[6], a[25:2], s[1:0]};
  endfunction

  function automatic logic [4:0] ref_mode(int k, logic c32);
    if (!c32) return (k == 7) ? 5'h01 : (k == 6) ? 5'h02 : 5'h03;
    if (k == 0 || k == 2) return 5'h13;
    if (k == 1) return 5'h1B;
    if (k == 3 || k == 4) return 5'h17;
    if (k == 5) return 5'h03;
    if (k == 6) return 5'h12;
    return 5'h11;
  endfunction

  function automatic logic [2:0] ref_bank(int k, logic c32);
    if (k == 7) return 3'd4;
    if (k == 6) return 3'd3;
    if (c32 && k == 1) return 3'd2;
    if (c32 && (k == 3 || k == 4)) return 3'd1;
    return 3'd0;
  endfunction

  // one entry with a single winner k, checks all results
  task automatic run_entry(logic c32, logic [7:0] r, int k, logic [31:0] p, logic [31:0] s);
    logic [4:0]  m;
    logic [31:0] es, ep, base, el;
    m = ref_mode(k, c32);
    if (k == 0) es = {24'h0, 2'b11, 1'b0, m};
    else        es = {s[31:8], 1'b1, s[6] | (k == 7), s[5], m};
    ep   = m[4] ? 32'(4 * k) : pk(es, 32'(4 * k));
    base = c32 ? (s[4] ? p : (p & 32'h03FF_FFFC)) : pk(s, p);
    el   = (k == 0) ? base : base - 32'd4;
    @(negedge clk);
    cfg32 = c32; req = r; pc = p; st = s;
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("R2 strobe k=%0d", k), 32'(entry), 32'd1);
    chk($sformatf("R3 ack k=%0d", k), 32'(ack), 32'(8'h01 << k));
    chk($sformatf("R5_R6_R8 status k=%0d c32=%0d", k, c32), nst, es);
    chk($sformatf("R4_R10 pc k=%0d c32=%0d", k, c32), npc, ep);
    chk($sformatf("R7 bank k=%0d c32=%0d", k, c32), 32'(bank), 32'(ref_bank(k, c32)));
    chk($sformatf("R7 saved k=%0d", k), sdata, s);
    chk($sformatf("R9_R10 link k=%0d c32=%0d", k, c32), lr, el);
    req = '0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 strobe drops", 32'(entry), 32'd0);
  endtask

  task automatic t_reset_state();
    chk("R1 entry in reset", 32'(entry), 32'd0);
    chk("R1 ack in reset", 32'(ack), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 entry after reset", 32'(entry), 32'd0);
  endtask

  task automatic t_all_codes(logic c32);
    for (int k = 0; k < 8; k++) begin
      run_entry(c32, 8'h01 << k, k, 32'h0000_1230 + 32'(k * 16),
                c32 ? 32'h6000_0010 : 32'hA000_0000);
      run_entry(c32, 8'h01 << k, k, 32'h0040_0104 + 32'(k * 8),
                c32 ? 32'h5000_0053 : 32'h1000_0042);
    end
  endtask

  task automatic t_reset_values();
    run_entry(1'b1, 8'h01, 0, 32'h0000_0100, 32'hF000_00D0);
    chk("R11 status32", nst, 32'h0000_00D3);
    chk("R11 pc32", npc, 32'h0000_0000);
    run_entry(1'b0, 8'h01, 0, 32'h0000_0100, 32'hF000_0000);
    chk("R11 status26", nst, 32'h0000_00C3);
    chk("R11 pc26", npc, 32'h0C00_0003);
  endtask

  task automatic t_legacy_in_32();
    run_entry(1'b1, 8'h02, 1, 32'hF000_1008, 32'h2000_0001);
    chk("R9 legacy link", lr, 32'h0000_1004);
    run_entry(1'b1, 8'h20, 5, 32'h0000_2000, 32'h6000_0010);
    chk("R5 addr pc", npc, 32'h6800_0017);
  endtask

  task automatic t_priority();
    run_entry(1'b1, 8'hFF, 0, 32'h100, 32'h10);
    run_entry(1'b1, 8'hFE, 4, 32'h100, 32'h10);
    run_entry(1'b1, 8'hE8, 5, 32'h100, 32'h10);
    run_entry(1'b1, 8'hC8, 7, 32'h100, 32'h10);
    run_entry(1'b0, 8'h4A, 6, 32'h100, 32'h0);
    run_entry(1'b0, 8'h0E, 3, 32'h100, 32'h0);
    run_entry(1'b1, 8'h06, 1, 32'h100, 32'h10);
  endtask

  task automatic t_idle();
    @(negedge clk); req = '0; pc = 32'hDEAD_BEE0; st = 32'h13;
    @(posedge clk); @(negedge clk);
    chk("R2 idle entry", 32'(entry), 32'd0);
    chk("R2 idle ack", 32'(ack), 32'd0);
  endtask

  initial begin
    #1;
    t_reset_state();
    t_idle();
    t_all_codes(1'b1);
    t_all_codes(1'b0);
    t_reset_values();
    t_legacy_in_32();
    t_priority();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule